// File: doc/BRIEF.md
# PHY Test-Port Configuration Register Bank

This block is the slave end of a narrow two-word test port that fills a bank of 8-bit PHY configuration registers. A host writes two words. The control word carries a strobe bit and a clear bit. The data word carries either a register address, marked by a flag bit, or a register value. Each rising edge of the strobe bit starts one action. If the flag is set, the action latches the address. If the flag is clear, the action writes the value into the register at the latched address. A rising edge of the clear bit returns the whole bank to its default state.

The stored values appear as parallel outputs for the analog side. These are the clock-lane timing bytes, the timing bytes of each data lane, the transmit clock select, and the PLL divider and filter fields unpacked from their configuration bytes. A combinational read port returns any register by its address.

Top module: `phy_tst_regbank`

## Requirements
- R1: After reset every register holds 0x00 and no address is latched. A read of address 0x65 returns 0xA0, because its bits 7:5 always read 3'b101.
- R2: An action fires only in a cycle where a control-word write (`wr_sel_i`=0) sets bit 1 to 1 while the previously written control word had bit 1 at 0. Writing bit 1 high again, or writing 0x00, starts no action.
- R3: An action taken while data-word bit 16 is 1 latches data-word bits 7:0 as the address and changes no register.
- R4: An action taken while data-word bit 16 is 0, with an address latched, stores data-word bits 7:0 into the addressed register. The new value is visible on the outputs after the same clock edge that accepts the control write.
- R5: An action with bit 16 at 0 and no address latched (after reset or clear) changes nothing.
- R6: The latched address survives data writes, so further value actions rewrite the same register without a new address phase.
- R7: A control-word write that raises bit 0 returns every register to 0x00 and forgets the latched address. If bit 1 rises in the same write, the clear wins and no action is taken.
- R8: Address map. Clock lane registers sit at 0x00–0x04: LPX, HS-prepare, HS-zero, HS-trail, wakeup. Data lane n (0..3) sits at 0x10·(n+1) + 0..6: LPX, HS-prepare, HS-zero, HS-trail, TA-go, TA-get, wakeup. Configuration registers sit at 0x60–0x65. Register at offset k drives `clk_lane_tmg_o[8k+:8]` or `data_lane_tmg_o[56n+8k+:8]`. 0x60 drives `tx_clk_sel_o`, 0x62 drives `pll_fbd_p_o` and 0x63 drives `pll_fbd_s_o`.
- R9: A value write to an address outside the map is dropped, and a read of such an address returns 0x00.
- R10: Register 0x61 unpacks as: bit 5 `pll_div5f_o`, bit 4 `pll_div1f_o`, bits 3:1 `pll_fbd_2p_o`, bit 0 `pll_enbwt_o`.
- R11: Register 0x64 unpacks as: bit 7 `pll_pre_div1p_o`, bits 6:0 `pll_pre_p_o`. Register 0x65 unpacks as: bit 4 `pll_vco_sel_o`, bits 3:2 `pll_lpf_rs_o`, bits 1:0 `pll_lpf_cs_o`. Its bits 7:5 read back as 3'b101 whatever was written.
- R12: `rd_data_o` shows the register at `rd_addr_i` combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write enable |
| wr_sel_i | input | 1 | 0 selects the control word, 1 selects the data word |
| wr_data_i | input | 32 | Host write value |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read value |
| clk_lane_tmg_o | output | 40 | Clock lane timing bytes |
| data_lane_tmg_o | output | 56·NUM_LANES | Data lane timing bytes |
| tx_clk_sel_o | output | 8 | Transmit clock select |
| pll_div5f_o | output | 1 | PLL feedback divide-by-5 flag |
| pll_div1f_o | output | 1 | PLL feedback divide-by-1 flag |
| pll_fbd_2p_o | output | 3 | PLL feedback 2p field |
| pll_enbwt_o | output | 1 | PLL bandwidth enable |
| pll_fbd_p_o | output | 8 | PLL feedback p field |
| pll_fbd_s_o | output | 8 | PLL feedback s field |
| pll_pre_div1p_o | output | 1 | PLL pre-divider bypass |
| pll_pre_p_o | output | 7 | PLL pre-divider value |
| pll_vco_sel_o | output | 1 | VCO range select |
| pll_lpf_rs_o | output | 2 | Loop filter resistor select |
| pll_lpf_cs_o | output | 2 | Loop filter capacitor select |

## Verification
The first pattern is the full two-phase write sequence swept over every mapped register of every lane. It separates correct address decode and output packing from swapped or aliased bytes. A second set of patterns breaks the normal sequence: a value strobe with no prior address, a strobe bit written high twice, repeated value strobes after one address phase, and a clear raised together with a strobe. These show whether actions follow strobe edges rather than levels, and whether the latched address is kept or dropped correctly. Writes and reads at holes in the map, and at the constant bits of the last configuration byte, separate decode gaps from partial decode.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;
  localparam int REG_W         = 8;
  localparam int ADDR_W        = 8;
  localparam int CTRL_W        = 32;
  localparam int CLR_BIT       = 0;
  localparam int STB_BIT       = 1;
  localparam int ADDR_FLAG_BIT = 16;
  localparam int CLK_REGS      = 5;
  localparam int LANE_REGS     = 7;
  localparam int CFG_REGS      = 6;
  localparam int CLK_BASE      = 'h00;
  localparam int LANE_BASE     = 'h10;
  localparam int LANE_STRIDE   = 'h10;
  localparam int CFG_BASE      = 'h60;
  localparam int CFG_TAG_IDX   = 5;
  localparam logic [2:0] CFG_TAG = 3'b101;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } bank_wr_t;
endpackage

// File: rtl/phy_tst_ctrl.sv
module phy_tst_ctrl
  import phy_tst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output bank_wr_t          wr_o,
  output logic              clr_o
);
  logic [1:0]        ctl_q;
  logic              flag_q;
  logic [REG_W-1:0]  word_q;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_vld_q;
  logic              ctl_wr, word_wr, clr_rise, stb_rise;
  logic              unused_hi;

  assign unused_hi = ^{wr_data_i[CTRL_W-1:ADDR_FLAG_BIT+1], wr_data_i[ADDR_FLAG_BIT-1:REG_W]};

  assign ctl_wr   = wr_en_i & ~wr_sel_i;
  assign word_wr  = wr_en_i & wr_sel_i;
  assign clr_rise = ctl_wr & wr_data_i[CLR_BIT] & ~ctl_q[CLR_BIT];
  // clear has priority over a coincident strobe edge
  assign stb_rise = ctl_wr & wr_data_i[STB_BIT] & ~ctl_q[STB_BIT] & ~clr_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      flag_q     <= 1'b0;
      word_q     <= '0;
      addr_q     <= '0;
      addr_vld_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= wr_data_i[STB_BIT:CLR_BIT];
      if (word_wr) begin
        flag_q <= wr_data_i[ADDR_FLAG_BIT];
        word_q <= wr_data_i[REG_W-1:0];
      end
      if (clr_rise) begin
        addr_vld_q <= 1'b0;
      end else if (stb_rise && flag_q) begin
        addr_q     <= word_q[ADDR_W-1:0];
        addr_vld_q <= 1'b1;
      end
    end
  end

  assign wr_o.we   = stb_rise & ~flag_q & addr_vld_q;
  assign wr_o.addr = addr_q;
  assign wr_o.data = word_q;
  assign clr_o     = clr_rise;

  // R2
  stb_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_rise |=> !stb_rise);
  // R3
  addr_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_rise && flag_q) |=> (addr_vld_q && addr_q == $past(word_q)));
  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o.we |=> (addr_vld_q && $stable(addr_q)));
  // R7
  clear_forget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rise |=> !addr_vld_q);
endmodule

// File: rtl/phy_tst_bank.sv
module phy_tst_bank
  import phy_tst_pkg::*;
#(
  parameter int BASE  = 0,
  parameter int NREGS = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  bank_wr_t               wr_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [NREGS*REG_W-1:0] regs_o,
  output logic [REG_W-1:0]       rd_data_o
);
  localparam logic [ADDR_W-1:0] LO  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] CNT = ADDR_W'(NREGS);

  logic [NREGS-1:0][REG_W-1:0] regs_q;
  logic [ADDR_W-1:0]           wr_off, rd_off;
  logic                        wr_hit, rd_hit;

  // wrap-around subtraction turns addresses below the base into large offsets
  assign wr_off = wr_i.addr - LO;
  assign rd_off = rd_addr_i - LO;
  assign wr_hit = wr_i.we && (wr_off < CNT);
  assign rd_hit = rd_off < CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (clr_i) begin
      regs_q <= '0;
    end else if (wr_hit) begin
      for (int i = 0; i < NREGS; i++)
        if (wr_off == ADDR_W'(i)) regs_q[i] <= wr_i.data;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_hit && rd_off == ADDR_W'(i)) rd_data_o = regs_q[i];
  end

  assign regs_o = regs_q;

  // R7
  bank_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (regs_q == '0));
  // R9
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hit && !clr_i) |=> $stable(regs_q));
endmodule

// File: rtl/phy_tst_cfg.sv
module phy_tst_cfg
  import phy_tst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  bank_wr_t          wr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [7:0]        tx_clk_sel_o,
  output logic              pll_div5f_o,
  output logic              pll_div1f_o,
  output logic [2:0]        pll_fbd_2p_o,
  output logic              pll_enbwt_o,
  output logic [7:0]        pll_fbd_p_o,
  output logic [7:0]        pll_fbd_s_o,
  output logic              pll_pre_div1p_o,
  output logic [6:0]        pll_pre_p_o,
  output logic              pll_vco_sel_o,
  output logic [1:0]        pll_lpf_rs_o,
  output logic [1:0]        pll_lpf_cs_o
);
  localparam logic [ADDR_W-1:0] TAG_ADDR = ADDR_W'(CFG_BASE + CFG_TAG_IDX);

  logic [CFG_REGS*REG_W-1:0]   flat;
  logic [CFG_REGS-1:0][REG_W-1:0] cfg;
  logic [REG_W-1:0]            raw_rd;
  logic                        unused_cfg;

  phy_tst_bank #(.BASE(CFG_BASE), .NREGS(CFG_REGS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .wr_i      (wr_i),
    .rd_addr_i (rd_addr_i),
    .regs_o    (flat),
    .rd_data_o (raw_rd)
  );

  assign cfg = flat;

  assign tx_clk_sel_o    = cfg[0];
  assign pll_div5f_o     = cfg[1][5];
  assign pll_div1f_o     = cfg[1][4];
  assign pll_fbd_2p_o    = cfg[1][3:1];
  assign pll_enbwt_o     = cfg[1][0];
  assign pll_fbd_p_o     = cfg[2];
  assign pll_fbd_s_o     = cfg[3];
  assign pll_pre_div1p_o = cfg[4][7];
  assign pll_pre_p_o     = cfg[4][6:0];
  assign pll_vco_sel_o   = cfg[5][4];
  assign pll_lpf_rs_o    = cfg[5][3:2];
  assign pll_lpf_cs_o    = cfg[5][1:0];
  assign unused_cfg      = ^{cfg[1][7:6], cfg[5][7:5]};

  assign rd_data_o = (rd_addr_i == TAG_ADDR) ? {CFG_TAG, raw_rd[4:0]} : raw_rd;

  // R11
  cfg_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == TAG_ADDR) |-> (rd_data_o[7:5] == CFG_TAG));
endmodule

// File: rtl/phy_tst_regbank.sv
module phy_tst_regbank
  import phy_tst_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic                               wr_sel_i,
  input  logic [31:0]                        wr_data_i,
  input  logic [7:0]                         rd_addr_i,
  output logic [7:0]                         rd_data_o,
  output logic [39:0]                        clk_lane_tmg_o,
  output logic [NUM_LANES*LANE_REGS*8-1:0]   data_lane_tmg_o,
  output logic [7:0]                         tx_clk_sel_o,
  output logic                               pll_div5f_o,
  output logic                               pll_div1f_o,
  output logic [2:0]                         pll_fbd_2p_o,
  output logic                               pll_enbwt_o,
  output logic [7:0]                         pll_fbd_p_o,
  output logic [7:0]                         pll_fbd_s_o,
  output logic                               pll_pre_div1p_o,
  output logic [6:0]                         pll_pre_p_o,
  output logic                               pll_vco_sel_o,
  output logic [1:0]                         pll_lpf_rs_o,
  output logic [1:0]                         pll_lpf_cs_o
);
  localparam int LANE_BITS = LANE_REGS * REG_W;
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(CFG_BASE + CFG_REGS);

  bank_wr_t         wr;
  logic             clr;
  logic [REG_W-1:0] clk_rd, cfg_rd;
  logic [REG_W-1:0] lane_rd [NUM_LANES];

  phy_tst_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .wr_o      (wr),
    .clr_o     (clr)
  );

  phy_tst_bank #(.BASE(CLK_BASE), .NREGS(CLK_REGS)) u_clk_lane (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_i      (wr),
    .rd_addr_i (rd_addr_i),
    .regs_o    (clk_lane_tmg_o),
    .rd_data_o (clk_rd)
  );

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    phy_tst_bank #(.BASE(LANE_BASE + n*LANE_STRIDE), .NREGS(LANE_REGS)) u_data_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .wr_i      (wr),
      .rd_addr_i (rd_addr_i),
      .regs_o    (data_lane_tmg_o[n*LANE_BITS +: LANE_BITS]),
      .rd_data_o (lane_rd[n])
    );
  end

  phy_tst_cfg u_cfg (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .clr_i           (clr),
    .wr_i            (wr),
    .rd_addr_i       (rd_addr_i),
    .rd_data_o       (cfg_rd),
    .tx_clk_sel_o    (tx_clk_sel_o),
    .pll_div5f_o     (pll_div5f_o),
    .pll_div1f_o     (pll_div1f_o),
    .pll_fbd_2p_o    (pll_fbd_2p_o),
    .pll_enbwt_o     (pll_enbwt_o),
    .pll_fbd_p_o     (pll_fbd_p_o),
    .pll_fbd_s_o     (pll_fbd_s_o),
    .pll_pre_div1p_o (pll_pre_div1p_o),
    .pll_pre_p_o     (pll_pre_p_o),
    .pll_vco_sel_o   (pll_vco_sel_o),
    .pll_lpf_rs_o    (pll_lpf_rs_o),
    .pll_lpf_cs_o    (pll_lpf_cs_o)
  );

  // banks return zero when not addressed, so an OR merges them
  always_comb begin
    rd_data_o = clk_rd | cfg_rd;
    for (int n = 0; n < NUM_LANES; n++) rd_data_o = rd_data_o | lane_rd[n];
  end

  // R9
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= MAP_END) |-> (rd_data_o == '0));
endmodule

// File: tb/phy_tst_regbank_test.sv
module phy_tst_regbank_test;
  localparam int CLK_P = 10;
  localparam int NL    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [39:0] clk_tmg;
  logic [NL*56-1:0] lane_tmg;
  logic [7:0] tx_sel, fbd_p, fbd_s;
  logic div5f, div1f, enbwt, div1p, vco;
  logic [2:0] fbd2p;
  logic [6:0] pre_p;
  logic [1:0] lpf_rs, lpf_cs;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [7:0] mem [256];
  logic [1:0] m_ctl = '0;
  logic [31:0] m_word = '0;
  logic [7:0] m_addr = '0;
  bit m_vld = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_tst_regbank #(.NUM_LANES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .clk_lane_tmg_o(clk_tmg), .data_lane_tmg_o(lane_tmg), .tx_clk_sel_o(tx_sel),
    .pll_div5f_o(div5f), .pll_div1f_o(div1f), .pll_fbd_2p_o(fbd2p),
    .pll_enbwt_o(enbwt), .pll_fbd_p_o(fbd_p), .pll_fbd_s_o(fbd_s),
    .pll_pre_div1p_o(div1p), .pll_pre_p_o(pre_p), .pll_vco_sel_o(vco),
    .pll_lpf_rs_o(lpf_rs), .pll_lpf_cs_o(lpf_cs)
  );

  // R8 map as seen by the model
  function automatic bit mapped(int a);
    return (a < 5) || (a >= 'h10 && a < 'h10 + 16*NL && (a % 16) < 7) ||
           (a >= 'h60 && a < 'h66);
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (!mapped(a)) return 8'h00;
    if (a == 'h65) return {3'b101, mem[a][4:0]}; // R11
    return mem[a];
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [39:0] e_clk;
    logic [NL*56-1:0] e_lane;
    logic [42:0] e_pll, a_pll;
    for (int k = 0; k < 5; k++) e_clk[8*k +: 8] = mem[k];
    for (int n = 0; n < NL; n++)
      for (int k = 0; k < 7; k++) e_lane[56*n + 8*k +: 8] = mem[16*(n+1) + k];
    e_pll = {mem['h60], mem['h61][5], mem['h61][4], mem['h61][3:1], mem['h61][0],
             mem['h62], mem['h63], mem['h64][7], mem['h64][6:0],
             mem['h65][4], mem['h65][3:2], mem['h65][1:0]};
    a_pll = {tx_sel, div5f, div1f, fbd2p, enbwt, fbd_p, fbd_s, div1p, pre_p, vco, lpf_rs, lpf_cs};
    chk(cur_req, 256'(clk_tmg), 256'(e_clk), "clock lane outputs");
    chk(cur_req, 256'(lane_tmg), 256'(e_lane), "data lane outputs");
    chk(cur_req, 256'(a_pll), 256'(e_pll), "config outputs");
    chk(cur_req, 256'(rd_data), 256'(exp_rd(int'(rd_addr))), "read port");
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) compare_all();
  end

  task automatic model_apply(bit sel, logic [31:0] d);
    bit clr_r, stb_r;
    if (sel) begin
      m_word = d;
      return;
    end
    clr_r = d[0] && !m_ctl[0];
    stb_r = d[1] && !m_ctl[1];
    m_ctl = d[1:0];
    if (clr_r) begin
      foreach (mem[i]) mem[i] = 8'h00;
      m_vld = 0;
    end else if (stb_r) begin
      if (m_word[16]) begin
        m_addr = m_word[7:0];
        m_vld = 1;
      end else if (m_vld && mapped(int'(m_addr))) begin
        mem[m_addr] = m_word[7:0];
      end
    end
  endtask

  task automatic host_wr(bit sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    model_apply(sel, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    host_wr(0, 32'h2);
    host_wr(0, 32'h0);
  endtask

  task automatic phy_write(logic [7:0] a, logic [7:0] v);
    host_wr(1, 32'h10000 | 32'(a));
    pulse();
    host_wr(1, 32'(v));
    pulse();
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] e);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, 256'(rd_data), 256'(e), "directed read");
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (mem[i]) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    rd_chk("R1", 8'h00, 8'h00);
    rd_chk("R1", 8'h65, 8'hA0);
    chk("R1", 256'(clk_tmg), 256'(0), "clock lane after reset");

    // R5 value strobe with no address latched
    cur_req = "R5";
    host_wr(1, 32'h0000_0055);
    pulse();
    rd_chk("R5", 8'h00, 8'h00);

    // R3 R4 R8 clock lane then every data lane
    cur_req = "R8";
    for (int k = 0; k < 5; k++) phy_write(8'(k), 8'(8'h11 * (k + 1)));
    chk("R4", 256'(clk_tmg[15:8]), 256'(8'h22), "clock HS-prepare byte");
    for (int n = 0; n < NL; n++)
      for (int k = 0; k < 7; k++) phy_write(8'(16*(n+1) + k), 8'(8'h80 + 16*n + k));
    chk("R8", 256'(lane_tmg[56*2 + 8*4 +: 8]), 256'(8'hA4), "lane 2 TA-go byte");

    // R3 address phase alone changes nothing
    cur_req = "R3";
    host_wr(1, 32'h10000 | 32'h03);
    pulse();
    rd_chk("R3", 8'h03, 8'h44);

    // R6 repeat value strobes without a new address
    cur_req = "R6";
    host_wr(1, 32'h0000_00C3);
    pulse();
    host_wr(1, 32'h0000_003C);
    pulse();
    rd_chk("R6", 8'h03, 8'h3C);

    // R2 strobe held high fires once
    cur_req = "R2";
    host_wr(1, 32'h0000_0077);
    host_wr(0, 32'h2);
    host_wr(1, 32'h0000_0099);
    host_wr(0, 32'h2);
    host_wr(0, 32'h0);
    rd_chk("R2", 8'h03, 8'h77);

    // R9 holes in the map
    cur_req = "R9";
    phy_write(8'h07, 8'h5A);
    phy_write(8'h17, 8'h5A);
    phy_write(8'h50, 8'h5A);
    phy_write(8'h66, 8'h5A);
    phy_write(8'hFF, 8'h5A);
    rd_chk("R9", 8'h17, 8'h00);
    rd_chk("R9", 8'hFF, 8'h00);

    // R10 R11 PLL fields
    cur_req = "R10";
    phy_write(8'h61, 8'h2B);
    chk("R10", 256'({div5f, div1f, fbd2p, enbwt}), 256'(6'b10_1011), "cfg I fields");
    cur_req = "R11";
    phy_write(8'h64, 8'h85);
    chk("R11", 256'({div1p, pre_p}), 256'({1'b1, 7'd5}), "cfg IV fields");
    phy_write(8'h65, 8'h1E);
    chk("R11", 256'({vco, lpf_rs, lpf_cs}), 256'(5'b1_11_10), "cfg V fields");
    rd_chk("R11", 8'h65, 8'hBE);
    phy_write(8'h65, 8'h00);
    rd_chk("R11", 8'h65, 8'hA0);
    phy_write(8'h60, 8'h06);
    phy_write(8'h62, 8'h03);
    phy_write(8'h63, 8'h02);

    // R7 clear, then a stale value strobe is ignored
    cur_req = "R7";
    host_wr(0, 32'h1);
    host_wr(0, 32'h0);
    rd_chk("R7", 8'h62, 8'h00);
    host_wr(1, 32'h0000_0042);
    pulse();
    rd_chk("R7", 8'h62, 8'h00);
    // clear and strobe rising together: clear wins
    phy_write(8'h02, 8'h66);
    host_wr(1, 32'h0000_0013);
    host_wr(0, 32'h3);
    host_wr(0, 32'h0);
    rd_chk("R7", 8'h02, 8'h00);

    // R12 full read sweep
    cur_req = "R12";
    phy_write(8'h44, 8'hE1);
    for (int a = 0; a < 256; a++) rd_chk("R12", 8'(a), exp_rd(a));

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule